// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

A single programmable down-counting channel. A load strobe sets the period N from a 16-bit load value, where the value zero means a full period of 65536. From then on the channel counts the elapsed count ticks d, which are the clocks on which the tick enable is high. The output level and the reported count are functions of d and N that depend on a 3-bit mode. There are four waveform shapes: a level that rises once when the count runs out, a one-tick low strobe, a periodic one-tick low pulse for rate generation, and a square wave. A gate input either pauses counting or restarts it, as set by the mode. Every low-to-high transition of the output also produces a one-clock rise pulse.

The channel is built around a four-state phase machine that tracks where d stands relative to N. PH_START means d is zero. PH_RUN means d is between zero and N. PH_TERM means d equals N. PH_PAST means d is beyond N. The transitions are as follows. A clear, caused by a load or a gate restart, moves any state to PH_START. A counted tick moves PH_START or PH_RUN to PH_TERM when d+1 equals N, and to PH_RUN otherwise. A counted tick moves PH_TERM to PH_PAST. PH_PAST holds until the next clear. A residue register keeps d mod N for the periodic shapes. A 16-bit elapsed register keeps d mod 65536 for the one-shot count readback.

Top module: `interval_counter_channel`

## Requirements
- R1: One clock after a load strobe, the count output equals the load value (truncated to 16 bits) in every mode, and d restarts from zero. A load wins over a tick and over a gate restart in the same clock.
- R2: A load value of 0 sets N = 65536. In mode 0 the count then reads 0, then 0xFFFF after one tick, and the output rises only after 65536 ticks. After reset the channel behaves as if 0 was just loaded.
- R3: Modes 0 and 1 (level shape): the output is low while d < N and high from d = N onwards. The count reads (N − d) mod 65536 and keeps decrementing past zero.
- R4: Mode 2 (rate): the output is low for exactly the ticks where d is a nonzero multiple of N and high otherwise. The count reads N − (d mod N).
- R5: Mode 3 (square): the output is high while (d mod N) < (N+1)/2 and low for the rest of each period. The count reads N − ((2·d) mod N), truncated to 16 bits.
- R6: Modes 4 and 5 (strobe): the output is low only while d = N and high otherwise. The count reads as in R3.
- R7: In modes 1, 2, 3 and 5, a gate transition from 0 to 1 restarts d at zero with the stored N.
- R8: In modes 0, 2, 3 and 4, ticks are not counted while the gate is 0. When the gate returns to 1, counting resumes from the held d without a restart.
- R9: In modes 1 and 5, ticks are counted whatever the gate level.
- R10: Mode 6 behaves exactly as mode 2, and mode 7 exactly as mode 3.
- R11: The rise output is 1 for exactly one clock after each clock edge at which the output level goes from 0 to 1, and 0 otherwise.
- R12: d advances by one only on clocks with the tick enable at 1. Clocks without it leave d unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count tick enable, one tick per high clock |
| mode_i | input | 3 | Counting mode 0..7 |
| load_stb_i | input | 1 | Load strobe, captures load_val_i as N |
| load_val_i | input | 16 | Period value, 0 means 65536 |
| gate_i | input | 1 | Gate level (pause or restart by mode) |
| count_o | output | 16 | Reported current count |
| out_o | output | 1 | Output level |
| rise_o | output | 1 | One-clock pulse on each output rise |

## Verification
The channel is driven with dense ticks (every clock) and sparse ticks (every third clock). This shows that d is tied to the tick enable and not to the clock. Odd and even periods, and the periods 1 and 2, are used in the rate and square modes. These expose off-by-one errors in the half-period threshold and in the doubled-count wrap. Gate sequences of low-then-high are replayed in every mode. They separate the three behaviours: pause, restart, and ignore. A long run with load value 0 checks the 65536 case, and a random mix of mode changes, loads and gate toggles is compared against an arithmetic model of d every clock.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

    typedef enum logic [1:0] {
        PH_START,
        PH_RUN,
        PH_TERM,
        PH_PAST
    } phase_e;

    typedef enum logic [1:0] {
        SH_LEVEL,
        SH_STROBE,
        SH_RATE,
        SH_SQUARE
    } shape_e;

    function automatic shape_e shape_of(input logic [2:0] mode);
        shape_e s;
        unique case (mode)
            3'd0, 3'd1: s = SH_LEVEL;
            3'd2, 3'd6: s = SH_RATE;
            3'd3, 3'd7: s = SH_SQUARE;
            3'd4, 3'd5: s = SH_STROBE;
            default:    s = SH_LEVEL;
        endcase
        return s;
    endfunction

    function automatic logic restarts_on_rise(input logic [2:0] mode);
        logic r;
        unique case (mode)
            3'd0, 3'd4: r = 1'b0;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic holds_on_low(input logic [2:0] mode);
        logic h;
        unique case (mode)
            3'd1, 3'd5: h = 1'b0;
            default:    h = 1'b1;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/ictr_sequencer.sv
module ictr_sequencer
    import ictr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [2:0]       mode_i,
    input  logic             load_stb_i,
    input  logic [W-1:0]     load_val_i,
    input  logic             gate_i,
    output logic [W:0]       span_o,
    output phase_e           phase_o,
    output logic [W-1:0]     elapsed_o,
    output logic             clear_o,
    output logic             step_o
);

    localparam int CW = W + 1;
    localparam logic [CW-1:0] FULL_SPAN = CW'(1) << W;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic            gate_q;
    logic            gate_rise;
    phase_e          phase_q;
    phase_e          phase_d;
    logic [CW-1:0]   span_q;
    logic [W-1:0]    elapsed_q;
    logic [CW-1:0]   elapsed_next;

    // Clear and step qualification from load, gate edge and mode rules.
    always_comb begin
        gate_rise    = gate_i & ~gate_q;
        clear_o      = load_stb_i | (gate_rise & restarts_on_rise(mode_i));
        step_o       = ~clear_o & tick_i & (gate_i | ~holds_on_low(mode_i));
        elapsed_next = {1'b0, elapsed_q} + ONE;
    end

    // Next-phase logic.
    always_comb begin
        phase_d = phase_q;
        if (clear_o) begin
            phase_d = PH_START;
        end else if (step_o) begin
            unique case (phase_q)
                PH_START, PH_RUN: phase_d = (elapsed_next == span_q) ? PH_TERM : PH_RUN;
                PH_TERM:          phase_d = PH_PAST;
                PH_PAST:          phase_d = PH_PAST;
                default:          phase_d = PH_PAST;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= PH_START;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Period, elapsed ticks and gate history.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gate_q    <= 1'b1;
            span_q    <= FULL_SPAN;
            elapsed_q <= '0;
        end else begin
            gate_q <= gate_i;
            if (load_stb_i) begin
                span_q <= (load_val_i == '0) ? FULL_SPAN : {1'b0, load_val_i};
            end
            if (clear_o) begin
                elapsed_q <= '0;
            end else if (step_o) begin
                elapsed_q <= elapsed_next[W-1:0];
            end
        end
    end

    assign span_o    = span_q;
    assign phase_o   = phase_q;
    assign elapsed_o = elapsed_q;

endmodule

// File: rtl/ictr_residue.sv
module ictr_residue #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic [W:0]   span_i,
    output logic [W:0]   resid_o
);

    localparam int CW = W + 1;

    logic [CW-1:0] resid_q;
    logic [CW-1:0] resid_inc;

    always_comb begin
        resid_inc = resid_q + CW'(1);
    end

    // Elapsed ticks modulo the period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            resid_q <= '0;
        end else if (clear_i) begin
            resid_q <= '0;
        end else if (step_i) begin
            resid_q <= (resid_inc == span_i) ? '0 : resid_inc;
        end
    end

    assign resid_o = resid_q;

endmodule

// File: rtl/ictr_wave.sv
module ictr_wave
    import ictr_pkg::*;
#(
    parameter int W = 16
) (
    input  shape_e         shape_i,
    input  phase_e         phase_i,
    input  logic [W-1:0]   elapsed_i,
    input  logic [W:0]     resid_i,
    input  logic [W:0]     span_i,
    output logic           out_o,
    output logic [W-1:0]   count_o
);

    localparam int CW = W + 1;

    logic [CW:0]   dbl;
    logic [CW:0]   dbl_less;
    logic [CW-1:0] dbl_mod;
    logic [CW:0]   span_up;
    logic [CW-1:0] half;

    // Doubled residue folded back into one period, and the half threshold.
    always_comb begin
        dbl      = {resid_i, 1'b0};
        dbl_less = dbl - {1'b0, span_i};
        dbl_mod  = (dbl >= {1'b0, span_i}) ? dbl_less[CW-1:0] : dbl[CW-1:0];
        span_up  = {1'b0, span_i} + (CW+1)'(1);
        half     = span_up[CW:1];
    end

    // Output decode per waveform shape.
    always_comb begin
        unique case (shape_i)
            SH_LEVEL: begin
                out_o   = (phase_i == PH_TERM) || (phase_i == PH_PAST);
                count_o = span_i[W-1:0] - elapsed_i;
            end
            SH_STROBE: begin
                out_o   = (phase_i != PH_TERM);
                count_o = span_i[W-1:0] - elapsed_i;
            end
            SH_RATE: begin
                out_o   = !((resid_i == '0) && (phase_i != PH_START));
                count_o = span_i[W-1:0] - resid_i[W-1:0];
            end
            SH_SQUARE: begin
                out_o   = (resid_i < half);
                count_o = span_i[W-1:0] - dbl_mod[W-1:0];
            end
            default: begin
                out_o   = 1'b0;
                count_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/ictr_edge.sv
module ictr_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o
);

    logic level_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            level_q <= 1'b1;
        end else begin
            level_q <= level_i;
        end
    end

    assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel
    import ictr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           tick_i,
    input  logic [2:0]     mode_i,
    input  logic           load_stb_i,
    input  logic [W-1:0]   load_val_i,
    input  logic           gate_i,
    output logic [W-1:0]   count_o,
    output logic           out_o,
    output logic           rise_o
);

    logic [W:0]     span;
    logic [W:0]     resid;
    logic [W-1:0]   elapsed;
    phase_e         phase;
    shape_e         shape;
    logic           clear;
    logic           step;

    assign shape = shape_of(mode_i);

    ictr_sequencer #(.W(W)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .mode_i     (mode_i),
        .load_stb_i (load_stb_i),
        .load_val_i (load_val_i),
        .gate_i     (gate_i),
        .span_o     (span),
        .phase_o    (phase),
        .elapsed_o  (elapsed),
        .clear_o    (clear),
        .step_o     (step)
    );

    ictr_residue #(.W(W)) u_res (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear),
        .step_i  (step),
        .span_i  (span),
        .resid_o (resid)
    );

    ictr_wave #(.W(W)) u_wave (
        .shape_i   (shape),
        .phase_i   (phase),
        .elapsed_i (elapsed),
        .resid_i   (resid),
        .span_i    (span),
        .out_o     (out_o),
        .count_o   (count_o)
    );

    ictr_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (out_o),
        .rise_o  (rise_o)
    );

endmodule

// File: rtl/interval_counter_channel_chk.sv
module interval_counter_channel_chk #(
    parameter int W = 16
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           tick_i,
    input logic [2:0]     mode_i,
    input logic           load_stb_i,
    input logic [W-1:0]   load_val_i,
    input logic           gate_i,
    input logic [W-1:0]   count_o,
    input logic           out_o,
    input logic           rise_o
);

    AST_LOAD_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_stb_i |=> (count_o == $past(load_val_i))); // R1

    AST_LEVEL_STAYS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 3'd0 && out_o && !load_stb_i) |=> (mode_i != 3'd0 || out_o)); // R3

    AST_RATE_PULSE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 3'd2 && !out_o && tick_i && gate_i && !load_stb_i && count_o != W'(1))
        |=> (mode_i != 3'd2 || out_o)); // R4

    AST_GATE_HOLDS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 3'd0 && !gate_i && !load_stb_i)
        |=> (mode_i != 3'd0 || count_o == $past(count_o))); // R8

    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o); // R11

endmodule

bind interval_counter_channel interval_counter_channel_chk #(.W(W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .mode_i     (mode_i),
    .load_stb_i (load_stb_i),
    .load_val_i (load_val_i),
    .gate_i     (gate_i),
    .count_o    (count_o),
    .out_o      (out_o),
    .rise_o     (rise_o)
);

// File: tb/interval_counter_channel_test.sv
module interval_counter_channel_test;

    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           tick;
    logic [2:0]     mode;
    logic           load_stb;
    logic [W-1:0]   load_val;
    logic           gate;
    logic [W-1:0]   count;
    logic           out;
    logic           rise;

    always #4 clk = ~clk;

    interval_counter_channel #(.W(W)) uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .mode_i     (mode),
        .load_stb_i (load_stb),
        .load_val_i (load_val),
        .gate_i     (gate),
        .count_o    (count),
        .out_o      (out),
        .rise_o     (rise)
    );

    int     checks = 0;
    int     fails  = 0;
    string  tag    = "R1";

    // Behavioural model: elapsed ticks as a plain integer.
    longint m_d    = 0;
    longint m_span = 65536;
    bit     m_gate_q = 1'b1;

    function automatic int eff(input logic [2:0] m);
        if (m == 3'd6) return 2;
        if (m == 3'd7) return 3;
        return int'(m);
    endfunction

    function automatic bit model_out(input logic [2:0] m);
        case (eff(m))
            0, 1:    return m_d >= m_span;
            2:       return !(((m_d % m_span) == 0) && (m_d != 0));
            3:       return (m_d % m_span) < ((m_span + 1) / 2);
            default: return m_d != m_span;
        endcase
    endfunction

    function automatic int model_count(input logic [2:0] m);
        longint v;
        case (eff(m))
            2:       v = m_span - (m_d % m_span);
            3:       v = m_span - ((2 * m_d) % m_span);
            default: v = m_span - m_d;
        endcase
        return int'(v & 64'hFFFF);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit t, input bit ld, input int v, input bit g, input logic [2:0] m);
        bit pre_out;
        bit post_out;
        int vv;
        @(negedge clk);
        tick = t; load_stb = ld; load_val = v[W-1:0]; gate = g; mode = m;
        pre_out = model_out(m);
        @(posedge clk);
        vv = v & 'hFFFF;
        if (ld) begin
            m_span = (vv == 0) ? 65536 : vv;
            m_d = 0;
        end else if (g && !m_gate_q && (eff(m) inside {1, 2, 3, 5})) begin
            m_d = 0;
        end else if (t && (g || !(eff(m) inside {0, 2, 3, 4}))) begin
            m_d++;
        end
        m_gate_q = g;
        #2;
        post_out = model_out(m);
        check({tag, " count"}, 32'(count), 32'(model_count(m)));
        check({tag, " out"}, 32'(out), 32'(post_out));
        check("R11 rise", 32'(rise), 32'(post_out && !pre_out));
    endtask

    task automatic run(input int n, input bit t, input bit g, input logic [2:0] m);
        for (int i = 0; i < n; i++) step(t, 1'b0, 0, g, m);
    endtask

    task automatic run_sparse(input int n, input bit g, input logic [2:0] m);
        for (int i = 0; i < n; i++) step((i % 3) == 2, 1'b0, 0, g, m);
    endtask

    task automatic gate_pulse(input logic [2:0] m, input int low_ticks);
        run(low_ticks, 1'b1, 1'b0, m);
        run(6, 1'b1, 1'b1, m);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; load_stb = 1'b0; load_val = '0; gate = 1'b1; mode = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2: reset acts as a load of 0 (N = 65536), mode 0 output low
        check("R2 reset count", 32'(count), 32'd0);
        check("R3 reset out", 32'(out), 32'd0);
        check("R11 reset rise", 32'(rise), 32'd0);

        // R3 level shape, dense and sparse ticks (R12)
        tag = "R3 mode0";
        step(1'b0, 1'b1, 5, 1'b1, 3'd0);
        run(10, 1'b1, 1'b1, 3'd0);
        tag = "R12 sparse";
        step(1'b0, 1'b1, 4, 1'b1, 3'd1);
        run_sparse(18, 1'b1, 3'd1);

        // R1 load wins over tick mid-count
        tag = "R1 load";
        step(1'b0, 1'b1, 9, 1'b1, 3'd0);
        run(3, 1'b1, 1'b1, 3'd0);
        step(1'b1, 1'b1, 300, 1'b1, 3'd0);
        run(4, 1'b1, 1'b1, 3'd0);

        // R4 rate shape, periods 4, 1, 2
        tag = "R4 mode2";
        step(1'b0, 1'b1, 4, 1'b1, 3'd2);
        run(20, 1'b1, 1'b1, 3'd2);
        step(1'b0, 1'b1, 1, 1'b1, 3'd2);
        run(5, 1'b1, 1'b1, 3'd2);
        step(1'b0, 1'b1, 2, 1'b1, 3'd2);
        run(8, 1'b1, 1'b1, 3'd2);

        // R5 square shape, odd and even periods, period 1
        tag = "R5 mode3";
        step(1'b0, 1'b1, 5, 1'b1, 3'd3);
        run(22, 1'b1, 1'b1, 3'd3);
        step(1'b0, 1'b1, 6, 1'b1, 3'd3);
        run(22, 1'b1, 1'b1, 3'd3);
        step(1'b0, 1'b1, 1, 1'b1, 3'd3);
        run(4, 1'b1, 1'b1, 3'd3);

        // R6 strobe shape
        tag = "R6 mode4";
        step(1'b0, 1'b1, 3, 1'b1, 3'd4);
        run(8, 1'b1, 1'b1, 3'd4);
        tag = "R6 mode5";
        step(1'b0, 1'b1, 3, 1'b1, 3'd5);
        run(8, 1'b1, 1'b1, 3'd5);

        // R7 gate rising edge restarts
        tag = "R7 restart";
        for (int m = 1; m <= 5; m++) begin
            if (m == 4) continue;
            step(1'b0, 1'b1, 4, 1'b1, 3'(m));
            run(7, 1'b1, 1'b1, 3'(m));
            gate_pulse(3'(m), 2);
        end

        // R8 gate low holds in modes 0, 2, 3, 4
        tag = "R8 hold";
        for (int m = 0; m <= 4; m++) begin
            if (m == 1) continue;
            step(1'b0, 1'b1, 10, 1'b1, 3'(m));
            run(3, 1'b1, 1'b1, 3'(m));
            gate_pulse(3'(m), 5);
        end

        // R9 gate level ignored by modes 1 and 5
        tag = "R9 ignore";
        step(1'b0, 1'b1, 6, 1'b1, 3'd1);
        step(1'b1, 1'b0, 0, 1'b1, 3'd1);
        run(8, 1'b1, 1'b0, 3'd1);
        step(1'b0, 1'b1, 6, 1'b0, 3'd5);
        run(8, 1'b1, 1'b0, 3'd5);

        // R10 modes 6 and 7 alias 2 and 3
        tag = "R10 alias";
        step(1'b0, 1'b1, 4, 1'b1, 3'd6);
        run(12, 1'b1, 1'b1, 3'd6);
        gate_pulse(3'd6, 3);
        step(1'b0, 1'b1, 5, 1'b1, 3'd7);
        run(14, 1'b1, 1'b1, 3'd7);
        gate_pulse(3'd7, 3);

        // R2 zero load means 65536 ticks
        tag = "R2 full";
        step(1'b0, 1'b1, 0, 1'b1, 3'd0);
        run(65540, 1'b1, 1'b1, 3'd0);

        // R12 random mix of ticks, loads, gate and modes
        tag = "R12 mix";
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom % 2), ($urandom % 16) == 0, int'($urandom % 9),
                 ($urandom % 8) != 0, 3'($urandom % 8));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule